// File: doc/BRIEF.md
# Dual-Width Scratchpad with Address Checking

This block is the data scratchpad of a wide-datapath processor. Storage is organised as 256-bit words. Two kinds of request reach the same array. A wide request loads or stores a whole word. A narrow request loads or stores one 32-bit lane inside a word. Each request supplies a base and an offset, and the block adds them to form a 32-bit byte address.

Before any access, the block checks the address for alignment and range. A wide request also has its register index checked. A request that fails a check is suppressed and produces a one-cycle error pulse. The failure is also recorded in a sticky error register, and that register raises a halt-pending flag.

Stores are not written at once. A store is staged, written into the array on a commit strobe, and thrown away on an abort strobe. This lets the surrounding pipeline cancel a store whose instruction never retires.

Top module: `dualwidth_scratchpad`

## Requirements
- R1: The byte address is `reqBase + reqOffset` truncated to 32 bits, so a sum that overflows wraps to a low address.
- R2: A wide request is valid only if address bits [4:0] are zero and address/32 is below `DEPTH`.
- R3: A narrow request is valid only if address bits [1:0] are zero and (address+3)/32, computed without truncation, is below `DEPTH`.
- R4: A narrow access uses lane (address/4) mod 8 of word address/32. Lane 0 occupies bits [31:0] and lane k occupies bits [32k+31:32k]. A narrow load returns the lane zero-extended. A narrow store changes only its own lane.
- R5: An invalid request reads nothing (`rdValid` stays low and `rdData` keeps its value) and writes nothing. One cycle after the request, `errValid` is high and `errCode` is 2'b01 (bit 0 means bad address).
- R6: On a wide request, a register index above 31 gives `errCode` 2'b10 (bit 1 means illegal instruction). This error takes priority: the address error is not reported with it, and the access is suppressed. Narrow requests ignore the index.
- R7: A staged store reaches the array only on a `commitIn` cycle with `abortIn` low. `abortIn` discards the staged store, including one requested in the same cycle. Until the commit, loads see the earlier contents.
- R8: The data of a valid load appears on `rdData` in the cycle after the request, marked by a one-cycle `rdValid` pulse.
- R9: `errSticky` accumulates the OR of every error code since reset. `haltPending` goes high together with the first error and stays high until reset.
- R10: `errValid` is a single-cycle pulse per failing request. `errCode` is zero whenever `errValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWide | input | 1 | 1 = 256-bit access, 0 = 32-bit lane access |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqBase | input | 32 | Base byte address |
| reqOffset | input | 32 | Offset added to the base |
| reqRegIdx | input | 6 | Wide-register index carried by wide requests |
| reqWdata | input | 256 | Store data (a narrow store uses bits [31:0]) |
| commitIn | input | 1 | Write the staged store into the array |
| abortIn | input | 1 | Discard the staged store |
| rdData | output | 256 | Load result |
| rdValid | output | 1 | Load result valid pulse |
| errValid | output | 1 | Error pulse |
| errCode | output | 2 | Error code: bit 0 bad address, bit 1 illegal index |
| errSticky | output | 2 | Accumulated error bits |
| haltPending | output | 1 | Halt requested since the first error |

## Verification
The assertions assume that `commitIn` is only raised after a store has been staged. They also assume that the surrounding pipeline never relies on a load and a commit to the same word in the same cycle. The stimulus meets both assumptions: every request, commit and abort goes in its own cycle, driven on the falling edge. The validity table resets the block before each entry, so an error from one entry cannot affect the next. The accumulation tests deliberately send two failing requests in a row to exercise the sticky register.

// File: rtl/spad_pkg.sv
package spad_pkg;
  localparam int LANE_W = 32;
  localparam int LANES  = 8;
  localparam int WORD_W = LANE_W * LANES;
  localparam int LANE_SEL_W = $clog2(LANES);
  localparam int ERR_W  = 2;

  localparam logic [ERR_W-1:0] ERR_NONE     = 2'b00;
  localparam logic [ERR_W-1:0] ERR_BAD_ADDR = 2'b01;
  localparam logic [ERR_W-1:0] ERR_ILLEGAL  = 2'b10;

  typedef struct packed {
    logic                  loadEn;
    logic                  stageEn;
    logic                  commitEn;
    logic                  dropEn;
    logic                  wide;
    logic [LANE_SEL_W-1:0] lane;
  } spad_strobe_t;
endpackage

// File: rtl/spad_ctrl.sv
module spad_ctrl
  import spad_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reqValid,
  input  logic                  reqWide,
  input  logic                  reqWrite,
  input  logic [31:0]           reqBase,
  input  logic [31:0]           reqOffset,
  input  logic [5:0]            reqRegIdx,
  input  logic                  commitIn,
  input  logic                  abortIn,
  output spad_strobe_t          strb,
  output logic [IDXW-1:0]       wordIdx,
  output logic                  errValid,
  output logic [ERR_W-1:0]      errCode,
  output logic [ERR_W-1:0]      errSticky,
  output logic                  haltPending
);
  localparam logic [32:0] DEPTH33 = 33'(DEPTH);

  logic [31:0]      effAddr;
  logic [32:0]      narrowEnd;
  logic             wideOk, narrowOk, addrOk, illegalIdx;
  logic [ERR_W-1:0] reqCode, seenCode;
  logic             goReq;

  // R1: modulo-2^32 address
  assign effAddr   = reqBase + reqOffset;
  assign narrowEnd = {1'b0, effAddr} + 33'd3;

  // R2 / R3 validity
  assign wideOk   = (effAddr[4:0] == 5'd0) && ({6'd0, effAddr[31:5]} < DEPTH33);
  assign narrowOk = (effAddr[1:0] == 2'd0) && ({5'd0, narrowEnd[32:5]} < DEPTH33);
  assign addrOk   = reqWide ? wideOk : narrowOk;

  // R6: index check only for wide requests, with priority
  assign illegalIdx = reqWide && (reqRegIdx > 6'd31);

  always_comb begin
    if (illegalIdx)   reqCode = ERR_ILLEGAL;
    else if (!addrOk) reqCode = ERR_BAD_ADDR;
    else              reqCode = ERR_NONE;
  end

  assign goReq    = reqValid && (reqCode == ERR_NONE);
  assign seenCode = reqValid ? reqCode : ERR_NONE;

  always_comb begin
    strb.loadEn   = goReq && !reqWrite;
    strb.stageEn  = goReq && reqWrite && !abortIn;
    strb.commitEn = commitIn && !abortIn;
    strb.dropEn   = abortIn;
    strb.wide     = reqWide;
    strb.lane     = effAddr[LANE_SEL_W+1:2];
  end

  assign wordIdx = effAddr[IDXW+4:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errValid    <= 1'b0;
      errCode     <= ERR_NONE;
      errSticky   <= ERR_NONE;
      haltPending <= 1'b0;
    end else begin
      errValid    <= (seenCode != ERR_NONE);
      errCode     <= seenCode;
      errSticky   <= errSticky | seenCode;
      haltPending <= haltPending | (seenCode != ERR_NONE);
    end
  end

  p_single_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    errValid |-> ($countones(errCode) == 1));
  p_code_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !errValid |-> (errCode == ERR_NONE));
  p_halt_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    haltPending |=> haltPending);
  p_err_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    errValid |-> (haltPending && ((errSticky & errCode) == errCode)));
  p_bad_suppressed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !addrOk) |-> (!strb.loadEn && !strb.stageEn));
endmodule

// File: rtl/spad_dpath.sv
module spad_dpath
  import spad_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  spad_strobe_t        strb,
  input  logic [IDXW-1:0]     wordIdx,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdData,
  output logic                rdValid
);
  logic [WORD_W-1:0] mem [DEPTH];

  logic              pendValid;
  logic [IDXW-1:0]   pendIdx;
  logic [WORD_W-1:0] pendData;
  logic [LANES-1:0]  pendMask;

  logic [WORD_W-1:0] stageData;
  logic [LANES-1:0]  stageMask;
  logic [WORD_W-1:0] rdWord;
  logic [WORD_W-1:0] rdNext;
  logic [LANE_W-1:0] rdLane;

  // R4: lane placement of a narrow store
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign stageMask[l] = strb.wide || (strb.lane == LANE_SEL_W'(l));
    assign stageData[l*LANE_W +: LANE_W] =
      strb.wide ? wdata[l*LANE_W +: LANE_W] : wdata[LANE_W-1:0];
  end

  // R7: staging register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendValid <= 1'b0;
      pendIdx   <= '0;
      pendData  <= '0;
      pendMask  <= '0;
    end else if (strb.dropEn) begin
      pendValid <= 1'b0;
    end else begin
      if (strb.commitEn) pendValid <= 1'b0;
      if (strb.stageEn) begin
        pendValid <= 1'b1;
        pendIdx   <= wordIdx;
        pendData  <= stageData;
        pendMask  <= stageMask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.commitEn && pendValid) begin
      for (int l = 0; l < LANES; l++) begin
        if (pendMask[l]) mem[pendIdx][l*LANE_W +: LANE_W] <= pendData[l*LANE_W +: LANE_W];
      end
    end
  end

  // R8: registered read
  assign rdWord = mem[wordIdx];
  assign rdLane = rdWord[{strb.lane, 5'd0} +: LANE_W];
  assign rdNext = strb.wide ? rdWord : {{(WORD_W-LANE_W){1'b0}}, rdLane};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.loadEn;
      if (strb.loadEn) rdData <= rdNext;
    end
  end

  p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.dropEn |=> !pendValid);
  p_load_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> $past(strb.loadEn));
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.loadEn |=> $stable(rdData));
endmodule

// File: rtl/dualwidth_scratchpad.sv
module dualwidth_scratchpad
  import spad_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWide,
  input  logic              reqWrite,
  input  logic [31:0]       reqBase,
  input  logic [31:0]       reqOffset,
  input  logic [5:0]        reqRegIdx,
  input  logic [255:0]      reqWdata,
  input  logic              commitIn,
  input  logic              abortIn,
  output logic [255:0]      rdData,
  output logic              rdValid,
  output logic              errValid,
  output logic [1:0]        errCode,
  output logic [1:0]        errSticky,
  output logic              haltPending
);
  localparam int IDXW = $clog2(DEPTH);

  spad_strobe_t    strb;
  logic [IDXW-1:0] wordIdx;

  spad_ctrl #(.DEPTH(DEPTH), .IDXW(IDXW)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqWide(reqWide), .reqWrite(reqWrite),
    .reqBase(reqBase), .reqOffset(reqOffset), .reqRegIdx(reqRegIdx),
    .commitIn(commitIn), .abortIn(abortIn),
    .strb(strb), .wordIdx(wordIdx),
    .errValid(errValid), .errCode(errCode),
    .errSticky(errSticky), .haltPending(haltPending)
  );

  spad_dpath #(.DEPTH(DEPTH), .IDXW(IDXW)) dpath_i (
    .clk(clk), .rst_n(rst_n),
    .strb(strb), .wordIdx(wordIdx), .wdata(reqWdata),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/dualwidth_scratchpad_tb_top.sv
module dualwidth_scratchpad_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reqValid = 1'b0, reqWide = 1'b0, reqWrite = 1'b0;
  logic [31:0]  reqBase = '0, reqOffset = '0;
  logic [5:0]   reqRegIdx = '0;
  logic [255:0] reqWdata = '0;
  logic         commitIn = 1'b0, abortIn = 1'b0;
  logic [255:0] rdData;
  logic         rdValid, errValid, haltPending;
  logic [1:0]   errCode, errSticky;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  dualwidth_scratchpad dut_i (.*);

  typedef struct packed {
    logic        wide;
    logic [31:0] base;
    logic [31:0] off;
    logic        ok;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 32'h0000_0000, 32'h0000_0000, 1'b1},
    '{1'b1, 32'h0000_0020, 32'h0000_0020, 1'b1},
    '{1'b1, 32'h0000_0FE0, 32'h0000_0000, 1'b1},
    '{1'b1, 32'h0000_1000, 32'h0000_0000, 1'b0},
    '{1'b1, 32'h0000_0010, 32'h0000_0000, 1'b0},
    '{1'b1, 32'hFFFF_FFF0, 32'h0000_0030, 1'b1},
    '{1'b0, 32'h0000_0FFC, 32'h0000_0000, 1'b1},
    '{1'b0, 32'h0000_1000, 32'h0000_0000, 1'b0},
    '{1'b0, 32'h0000_0002, 32'h0000_0000, 1'b0},
    '{1'b0, 32'h0000_0100, 32'h0000_0004, 1'b1},
    '{1'b0, 32'hFFFF_FFFC, 32'h0000_0000, 1'b0},
    '{1'b1, 32'hFFFF_FFE0, 32'h0000_0000, 1'b0}
  };

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive on a falling edge; return on the next falling edge (one rising edge passed)
  task automatic issue(input logic wide, input logic write, input logic [31:0] base,
                       input logic [31:0] off, input logic [5:0] idx, input logic [255:0] data);
    @(negedge clk);
    reqValid = 1'b1; reqWide = wide; reqWrite = write;
    reqBase = base; reqOffset = off; reqRegIdx = idx; reqWdata = data;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic strobe(input logic c, input logic a);
    @(negedge clk);
    commitIn = c; abortIn = a;
    @(negedge clk);
    commitIn = 1'b0; abortIn = 1'b0;
  endtask

  function automatic logic [255:0] pat(input logic [31:0] seed);
    logic [255:0] p;
    for (int l = 0; l < 8; l++) p[l*32 +: 32] = seed + 32'(l);
    return p;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [255:0] p, q, merged;
    p = pat(32'h1100_0000);
    q = pat(32'h2200_0000);

    doReset();
    chk("R9 reset sticky", 256'(errSticky), 256'd0);
    chk("R9 reset halt", 256'(haltPending), 256'd0);
    chk("R8 reset rdValid", 256'(rdValid), 256'd0);
    chk("R10 reset errValid", 256'(errValid), 256'd0);

    // table: address validity (R1, R2, R3, R5)
    for (int i = 0; i < 12; i++) begin
      doReset();
      issue(VECS[i].wide, 1'b0, VECS[i].base, VECS[i].off, 6'd0, '0);
      chk($sformatf("R2 R3 R1 vec%0d rdValid", i), 256'(rdValid), 256'(VECS[i].ok));
      chk($sformatf("R5 vec%0d errCode", i), 256'(errCode), VECS[i].ok ? 256'd0 : 256'd1);
    end

    doReset();
    // R7 R8: wide store, commit, load
    issue(1'b1, 1'b1, 32'h60, 32'h0, 6'd3, p);
    strobe(1'b1, 1'b0);
    issue(1'b1, 1'b0, 32'h40, 32'h20, 6'd3, '0);
    chk("R8 wide load data", rdData, p);
    chk("R8 rdValid high", 256'(rdValid), 256'd1);
    @(negedge clk);
    chk("R8 rdValid pulse ends", 256'(rdValid), 256'd0);

    // R7: uncommitted store invisible, then dropped by abort
    issue(1'b1, 1'b1, 32'h60, 32'h0, 6'd3, q);
    issue(1'b1, 1'b0, 32'h60, 32'h0, 6'd3, '0);
    chk("R7 before commit", rdData, p);
    strobe(1'b0, 1'b1);
    strobe(1'b1, 1'b0);
    issue(1'b1, 1'b0, 32'h60, 32'h0, 6'd3, '0);
    chk("R7 aborted store dropped", rdData, p);

    // R4: narrow store into lane 2 of word 3
    issue(1'b0, 1'b1, 32'h68, 32'h0, 6'd0, {224'd0, 32'hDEAD_BEEF});
    strobe(1'b1, 1'b0);
    merged = p;
    merged[64 +: 32] = 32'hDEAD_BEEF;
    issue(1'b1, 1'b0, 32'h60, 32'h0, 6'd0, '0);
    chk("R4 lane-only write", rdData, merged);
    issue(1'b0, 1'b0, 32'h64, 32'h4, 6'd0, '0);
    chk("R4 narrow load lane2", rdData, {224'd0, 32'hDEAD_BEEF});
    issue(1'b0, 1'b0, 32'h64, 32'h0, 6'd0, '0);
    chk("R4 narrow load lane1", rdData, {224'd0, 32'h1100_0001});
    issue(1'b0, 1'b0, 32'h7C, 32'h0, 6'd40, '0);
    chk("R6 narrow ignores index", 256'(errValid), 256'd0);
    chk("R4 narrow load lane7", rdData, {224'd0, 32'h1100_0007});

    // R5: misaligned store suppressed; read data held
    issue(1'b1, 1'b1, 32'h61, 32'h0, 6'd0, q);
    chk("R5 bad store rdData held", rdData, {224'd0, 32'h1100_0007});
    chk("R5 bad store err", 256'(errCode), 256'd1);
    strobe(1'b1, 1'b0);
    doReset();
    issue(1'b1, 1'b0, 32'h60, 32'h0, 6'd0, '0);
    chk("R5 memory untouched", rdData, merged);

    // R6: illegal index has priority over bad address
    doReset();
    issue(1'b1, 1'b0, 32'h11, 32'h0, 6'd40, '0);
    chk("R6 priority code", 256'(errCode), 256'd2);
    chk("R6 no load", 256'(rdValid), 256'd0);
    @(negedge clk);
    chk("R10 pulse ends", 256'(errValid), 256'd0);
    chk("R10 code quiet", 256'(errCode), 256'd0);
    chk("R9 halt held", 256'(haltPending), 256'd1);

    // R9: accumulation
    issue(1'b0, 1'b0, 32'h3, 32'h0, 6'd0, '0);
    chk("R9 sticky or", 256'(errSticky), 256'd3);
    issue(1'b1, 1'b0, 32'h60, 32'h0, 6'd32, '0);
    chk("R6 index 32 illegal", 256'(errCode), 256'd2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule